// File: doc/BRIEF.md
# Cascadable Column Driver Core

This block is the logic core of a 64-column display driver. Four parallel 16-stage shift registers accept one 4-bit nibble per accepted clock edge, so sixteen transfers fill all 64 columns. A direction input selects which of the two nibble ports feeds the registers. The other port presents the nibble leaving the far end of each register, which lets drivers be chained to any panel width.

A strobe-controlled holding stage sits between the shift registers and the columns. While the strobe is low it is transparent. While the strobe is high it keeps the register contents captured at the last edge before the strobe rose. Each column output is then conditioned by a high-impedance control, a blanking control and a polarity control. Tri-state outputs are modelled as a value vector plus an enable vector.

Nibbles enter through a valid/ready pair. The core never applies back-pressure: `in_ready` is always high, and a nibble is taken on every rising edge where `in_valid` is high. The cascade output carries no handshake. A downstream driver must be fed with the same `in_valid` so that both chains move together.

Top module: `column_drive_core`

## Requirements
- R1: A shift happens on a rising clock edge only when `in_valid` is high. `in_ready` is always 1. With `in_valid` low, all register contents and both cascade outputs keep their values.
- R2: With `rev_dir` = 0 (forward), nibbles enter from `a_in`. `b_oe` = 1, `a_oe` = 0, and `b_out` shows the nibble accepted 16 shifts earlier.
- R3: With `rev_dir` = 1 (reverse), nibbles enter from `b_in`. `a_oe` = 1, `b_oe` = 0, and `a_out` shows the nibble accepted 16 shifts earlier.
- R4: Stage s (0 at the A end, 15 at the B end) of lane l holds column index s*4+l (0-based). Bit l of each nibble feeds lane l. After 16 forward shifts, the first nibble occupies columns 63:60. After 16 reverse shifts, it occupies columns 3:0.
- R5: While `strobe` = 0, the columns follow the register contents in the same cycle as a shift.
- R6: While `strobe` = 1, the columns keep the contents present when the strobe rose, whatever shifts occur.
- R7: `hiz_n` = 0 makes `col_oe` all zero and `col_out` all zero, whatever the other controls are.
- R8: With `hiz_n` = 1 and `blank_n` = 0, every column equals `pol` and `col_oe` is all ones.
- R9: With `hiz_n` = 1 and `blank_n` = 1, each column equals its held bit when `pol` = 1 and its inverse when `pol` = 0.
- R10: An active-low `rst_n` clears the shift registers and the holding stage to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rev_dir | input | 1 | 0 forward (A in, B out), 1 reverse (B in, A out) |
| in_valid | input | 1 | Nibble on the input port is valid; shift when high |
| in_ready | output | 1 | Always high, no back-pressure |
| a_in | input | 4 | A port input nibble |
| a_out | output | 4 | A port cascade nibble (stage 0 of each lane) |
| a_oe | output | 1 | A port drives (reverse mode) |
| b_in | input | 4 | B port input nibble |
| b_out | output | 4 | B port cascade nibble (stage 15 of each lane) |
| b_oe | output | 1 | B port drives (forward mode) |
| strobe | input | 1 | 0 transparent, 1 hold |
| hiz_n | input | 1 | 0 puts all columns in high impedance |
| blank_n | input | 1 | 0 forces all columns to `pol` |
| pol | input | 1 | Polarity: 1 true data, 0 inverted |
| col_out | output | 64 | Column values |
| col_oe | output | 64 | Column output enables |

## Verification
On every cycle, the assertions check these properties: nibble entry at the correct end of each lane, that stalled cycles keep the registers, that the held value stays frozen while the strobe is high, the one-hot port drive, and the relation between the control pins and the column enables and values. Several behaviours need the bench's scenarios and its behavioural model compared on every clock: the 16-shift cascade delay in both directions, the column mapping of each lane and stage, snapshot timing as the strobe rises, and inversion under low polarity.

// File: rtl/coldrv_pkg.sv
`timescale 1ns/1ps
package coldrv_pkg;
  typedef enum logic {DIR_FWD = 1'b0, DIR_REV = 1'b1} shift_dir_e;
endpackage

// File: rtl/coldrv_lane.sv
`timescale 1ns/1ps
// One bidirectional shift lane; stage 0 sits at the A end.
module coldrv_lane
  import coldrv_pkg::*;
#(
  parameter int STAGES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  shift_dir_e        dir,
  input  logic              fwd_in,
  input  logic              rev_in,
  output logic [STAGES-1:0] stages,
  output logic [STAGES-1:0] stages_next
);
  always_comb begin
    stages_next = stages;
    if (shift_en) begin
      if (dir == DIR_FWD) stages_next = {stages[STAGES-2:0], fwd_in};
      else                stages_next = {rev_in, stages[STAGES-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stages <= '0;
    else        stages <= stages_next;
  end

  assert_fwd_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && dir == DIR_FWD) |=> (stages[0] == $past(fwd_in)));
  assert_rev_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && dir == DIR_REV) |=> (stages[STAGES-1] == $past(rev_in)));
  assert_stall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(stages));
endmodule

// File: rtl/coldrv_latch.sv
`timescale 1ns/1ps
// Strobe-controlled holding stage: transparent while hold is low.
module coldrv_latch #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold,
  input  logic [W-1:0] d_now,
  input  logic [W-1:0] d_next,
  output logic [W-1:0] q
);
  logic [W-1:0] kept_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     kept_q <= '0;
    else if (!hold) kept_q <= d_next;
  end

  assign q = hold ? kept_q : d_now;

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && $past(hold)) |-> $stable(q));
endmodule

// File: rtl/coldrv_outstage.sv
`timescale 1ns/1ps
// Column conditioning: high impedance, blanking, polarity.
module coldrv_outstage #(
  parameter int W = 64
) (
  input  logic         hiz_n,
  input  logic         blank_n,
  input  logic         pol,
  input  logic [W-1:0] d,
  output logic [W-1:0] col_out,
  output logic [W-1:0] col_oe
);
  always_comb begin
    col_oe = {W{hiz_n}};
    if (!hiz_n)        col_out = '0;
    else if (!blank_n) col_out = {W{pol}};
    else               col_out = pol ? d : ~d;
  end
endmodule

// File: rtl/column_drive_core.sv
`timescale 1ns/1ps
module column_drive_core
  import coldrv_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int STAGES = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rev_dir,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [LANES-1:0]          a_in,
  output logic [LANES-1:0]          a_out,
  output logic                      a_oe,
  input  logic [LANES-1:0]          b_in,
  output logic [LANES-1:0]          b_out,
  output logic                      b_oe,
  input  logic                      strobe,
  input  logic                      hiz_n,
  input  logic                      blank_n,
  input  logic                      pol,
  output logic [LANES*STAGES-1:0]   col_out,
  output logic [LANES*STAGES-1:0]   col_oe
);
  localparam int COLS = LANES * STAGES;

  shift_dir_e       dir;
  logic             take;
  logic [COLS-1:0]  reg_now;
  logic [COLS-1:0]  reg_next;
  logic [COLS-1:0]  held;

  assign dir      = shift_dir_e'(rev_dir);
  assign in_ready = 1'b1;
  assign take     = in_valid && in_ready;
  assign a_oe     = (dir == DIR_REV);
  assign b_oe     = (dir == DIR_FWD);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [STAGES-1:0] st;
    logic [STAGES-1:0] st_nx;
    coldrv_lane #(.STAGES(STAGES)) u_lane (
      .clk(clk), .rst_n(rst_n), .shift_en(take), .dir(dir),
      .fwd_in(a_in[l]), .rev_in(b_in[l]),
      .stages(st), .stages_next(st_nx)
    );
    assign a_out[l] = st[0];
    assign b_out[l] = st[STAGES-1];
    for (genvar s = 0; s < STAGES; s++) begin : g_map
      assign reg_now[s*LANES+l]  = st[s];
      assign reg_next[s*LANES+l] = st_nx[s];
    end
  end

  coldrv_latch #(.W(COLS)) u_latch (
    .clk(clk), .rst_n(rst_n), .hold(strobe),
    .d_now(reg_now), .d_next(reg_next), .q(held)
  );

  coldrv_outstage #(.W(COLS)) u_out (
    .hiz_n(hiz_n), .blank_n(blank_n), .pol(pol), .d(held),
    .col_out(col_out), .col_oe(col_oe)
  );

  assert_port_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({a_oe, b_oe}) == 1);
  assert_hiz_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !hiz_n |-> (col_oe == '0 && col_out == '0));
  assert_blank_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hiz_n && !blank_n) |-> (col_out == {COLS{pol}} && col_oe == '1));
  assert_true_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hiz_n && blank_n && pol) |-> (col_out == held));
  assert_transparent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe && hiz_n && blank_n && pol) |-> (col_out == reg_now));
endmodule

// File: tb/sim_column_drive_core.sv
`timescale 1ns/1ps
module sim_column_drive_core;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, rev_dir, in_valid, in_ready, a_oe, b_oe;
  logic strobe, hiz_n, blank_n, pol;
  logic [3:0] a_in, a_out, b_in, b_out;
  logic [63:0] col_out, col_oe;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  column_drive_core u0 (
    .clk(clk), .rst_n(rst_n), .rev_dir(rev_dir), .in_valid(in_valid),
    .in_ready(in_ready), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe), .strobe(strobe),
    .hiz_n(hiz_n), .blank_n(blank_n), .pol(pol),
    .col_out(col_out), .col_oe(col_oe)
  );

  // Behavioural reference: one nibble per stage, stage 0 at the A end.
  logic [3:0] m_reg [16];
  logic [3:0] m_hold [16];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < 16; s++) begin m_reg[s] = 4'h0; m_hold[s] = 4'h0; end
    end else begin
      if (in_valid) begin
        if (!rev_dir) begin
          for (int s = 15; s > 0; s--) m_reg[s] = m_reg[s-1];
          m_reg[0] = a_in;
        end else begin
          for (int s = 0; s < 15; s++) m_reg[s] = m_reg[s+1];
          m_reg[15] = b_in;
        end
      end
      if (!strobe) for (int s = 0; s < 16; s++) m_hold[s] = m_reg[s];
    end
  end

  function automatic logic [63:0] exp_held();
    logic [63:0] v;
    for (int c = 0; c < 64; c++) v[c] = strobe ? m_hold[c/4][c%4] : m_reg[c/4][c%4];
    return v;
  endfunction

  function automatic logic [63:0] exp_cols();
    if (!hiz_n) return 64'h0;
    if (!blank_n) return {64{pol}};
    return pol ? exp_held() : ~exp_held();
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      string tg;
      if (!hiz_n) tg = "R7";
      else if (!blank_n) tg = "R8";
      else if (strobe) tg = "R6";
      else tg = "R9";
      chk(col_out === exp_cols(), tg, col_out, exp_cols());
      chk(col_oe === {64{hiz_n}}, "R7", col_oe, {64{hiz_n}});
      chk(a_out === m_reg[0] && b_out === m_reg[15], "R4",
          {56'h0, a_out, b_out}, {56'h0, m_reg[0], m_reg[15]});
      chk(a_oe === rev_dir && b_oe === !rev_dir && in_ready === 1'b1, "R1",
          {61'h0, in_ready, a_oe, b_oe}, {61'h0, 1'b1, rev_dir, !rev_dir});
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic shift(input logic [3:0] a, input logic [3:0] b, input logic v);
    a_in = a; b_in = b; in_valid = v;
    @(posedge clk); #1;
  endtask

  logic [63:0] snap;

  initial begin
    rst_n = 0; rev_dir = 0; in_valid = 0; strobe = 0;
    hiz_n = 1; blank_n = 1; pol = 1; a_in = 0; b_in = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(col_out === 64'h0, "R10", col_out, 64'h0);
    chk(col_oe === '1, "R10", col_oe, '1);
    rst_n = 1;

    // Forward fill with a stall in the middle.
    for (int i = 0; i < 16; i++) begin
      if (i == 5) begin
        snap = col_out;
        shift(4'hF, 4'hF, 1'b0);
        chk(col_out === snap, "R1", col_out, snap);
      end
      shift(4'((i * 7 + 3) & 15), 4'h0, 1'b1);
      if (i == 0) chk(col_out[3:0] === 4'h3, "R5", {60'h0, col_out[3:0]}, 64'h3);
    end
    chk(b_out === 4'h3 && b_oe === 1'b1, "R2", {59'h0, b_oe, b_out}, {59'h0, 1'b1, 4'h3});
    chk(col_out[63:60] === 4'h3, "R4", {60'h0, col_out[63:60]}, 64'h3);

    // Hold while shifting.
    strobe = 1; #1;
    snap = col_out;
    for (int i = 0; i < 5; i++) shift(4'(i + 9), 4'h0, 1'b1);
    chk(col_out === snap, "R6", col_out, snap);

    // Polarity, blanking and high impedance on the held data.
    pol = 0; #1;
    chk(col_out === ~snap, "R9", col_out, ~snap);
    blank_n = 0; #1;
    chk(col_out === 64'h0, "R8", col_out, 64'h0);
    pol = 1; #1;
    chk(col_out === '1, "R8", col_out, '1);
    hiz_n = 0; #1;
    chk(col_oe === 64'h0 && col_out === 64'h0, "R7", col_oe | col_out, 64'h0);
    shift(4'h1, 4'h0, 1'b0);
    hiz_n = 1; blank_n = 1; strobe = 0; #1;
    chk(col_out === exp_held(), "R5", col_out, exp_held());

    // Reverse fill.
    rev_dir = 1;
    for (int i = 0; i < 16; i++) begin
      if (i == 9) shift(4'h0, 4'h6, 1'b0);
      shift(4'h0, 4'((i * 5 + 10) & 15), 1'b1);
    end
    chk(a_out === 4'hA && a_oe === 1'b1 && b_oe === 1'b0, "R3",
        {58'h0, a_oe, b_oe, a_out}, {58'h0, 2'b10, 4'hA});
    chk(col_out[3:0] === 4'hA, "R4", {60'h0, col_out[3:0]}, 64'hA);

    // Strobe rising mid-stream in reverse with low polarity.
    strobe = 1; pol = 0; #1;
    snap = col_out;
    for (int i = 0; i < 3; i++) shift(4'h0, 4'(i), 1'b1);
    chk(col_out === snap, "R6", col_out, snap);

    // Reset clears everything.
    strobe = 0; pol = 1; rst_n = 0; #1;
    chk(col_out === 64'h0 && a_out === 4'h0, "R10", col_out, 64'h0);
    @(posedge clk); #1;
    rst_n = 1;
    @(negedge clk); #1;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule